// File: doc/BRIEF.md
# On-chip RAM window decoder

This block sits between a small CPU and its memory paths. It holds an 8-bit control register on the CPU register bus. One bit of that register, the RAM enable, decides where each CPU data access goes. When the enable is set, an access that lands inside a fixed on-chip RAM window selects the internal RAM. Every other access goes to the external data bus. Accesses to the register's own address select neither path.

The register also holds a standby enable, a 3-bit standby timer select and an NMI edge select. These bits are only stored and read back here; what they control lies outside this block. Two reserved bits always read as one.

The size of the window is a build-time choice among four windows, and all four end at 0xFF7F. Reset is synchronous and active high. Only reset initializes the stored bits; the software-standby indication leaves them alone.

Top module: `ramwin_top`

## Requirements
- R1: While `rst` is high the register loads 0x0B, so after reset a register read returns 0x0B and the RAM enable (bit 0) is 1.
- R2: Bits 3 and 1 of the register always read as 1, whatever value is written to them.
- R3: Bit 7 (standby enable), bits 6:4 (timer select), bit 2 (NMI edge select) and bit 0 (RAM enable) store the written value. A read strobe at address 0xFFC4 returns the register on `rdata_o` one clock later.
- R4: Holding `standby_i` high with no register write leaves every stored bit unchanged.
- R5: With the RAM enable at 1, any read or write inside the window asserts `ram_sel_o` and not `ext_sel_o`. For the default `WIN_SEL`=0 the window is 0xF780 to 0xFF7F. `WIN_SEL` values 1, 2 and 3 give windows that start at 0xFB80, 0xFD80 and 0xFE80.
- R6: With the RAM enable at 0 in an expanded mode, accesses inside the window assert `ext_sel_o` and not `ram_sel_o`.
- R7: In an expanded mode, accesses outside the window that are not to 0xFFC4 assert `ext_sel_o`. This includes the addresses just below and just above the window (0xF77F and 0xFF80 for `WIN_SEL`=0).
- R8: An access to 0xFFC4 asserts neither `ram_sel_o` nor `ext_sel_o`.
- R9: A register write takes effect at the next clock edge. A window access in the cycle right after a write that clears bit 0 goes external.
- R10: `ram_sel_o` and `ext_sel_o` are never high together, and both are low when no strobe is active.
- R11: Modes 1 and 2 (`mode_i` values 1 and 2) are expanded modes. In modes 0 and 3, `ext_sel_o` never asserts, while `ram_sel_o` still follows the window and the RAM enable.
- R12: While `standby_i` is high, neither select asserts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 16 | CPU address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| standby_i | input | 1 | Software-standby indication |
| mode_i | input | 2 | Operating mode |
| ram_sel_o | output | 1 | Access routed to internal RAM |
| ext_sel_o | output | 1 | Access routed to external bus |
| rdata_o | output | 8 | Registered register read data |

## Verification
The hardest situation to bring about is the handover in R9. A window access must land in the very cycle after a write clears the RAM enable, and it must be routed externally with no stale-enable gap. The driver issues the clearing write and then, at the next negedge, a window access, and checks the selects one time unit later. The check for R4 is a second hard case. The stimulus first writes a recognizable pattern, then holds standby for several cycles, and finally reads the register back through the bus.

// File: rtl/ramwin_pkg.sv
package ramwin_pkg;
  typedef struct packed {
    logic       sby_en;
    logic [2:0] tmr_sel;
    logic       nmi_edge;
    logic       ram_en;
  } ctl_t;

  localparam logic [7:0] CTL_RESET = 8'h0B;

  function automatic logic [7:0] ctl_pack(input ctl_t c);
    return {c.sby_en, c.tmr_sel, 1'b1, c.nmi_edge, 1'b1, c.ram_en};
  endfunction

  function automatic ctl_t ctl_unpack(input logic [7:0] d);
    ctl_t c;
    c.sby_en   = d[7];
    c.tmr_sel  = d[6:4];
    c.nmi_edge = d[2];
    c.ram_en   = d[0];
    return c;
  endfunction
endpackage

// File: rtl/ramwin_ctlreg.sv
module ramwin_ctlreg
  import ramwin_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output ctl_t              ctl_q,
  output logic [DATA_W-1:0] rdata_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= ctl_unpack(CTL_RESET);
      rdata_q <= '0;
    end else begin
      if (wr_en) ctl_q <= ctl_unpack(wdata);
      if (rd_en) rdata_q <= ctl_pack(ctl_q);
    end
  end

  // R1
  reset_value_chk: assert property (@(posedge clk)
    $fell(rst) |-> (ctl_pack(ctl_q) == CTL_RESET));
endmodule

// File: rtl/ramwin_decode.sv
module ramwin_decode #(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] WIN_BASE = 16'hF780,
  parameter logic [15:0] WIN_END  = 16'hFF7F,
  parameter logic [15:0] REG_ADDR = 16'hFFC4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic              ram_en,
  input  logic              expanded,
  input  logic              standby,
  output logic              reg_hit,
  output logic              ram_sel,
  output logic              ext_sel
);
  logic access, in_win, to_ram;

  always_comb begin
    access  = rd | wr;
    in_win  = (addr >= WIN_BASE) && (addr <= WIN_END);
    reg_hit = (addr == REG_ADDR);
    to_ram  = in_win & ram_en;
    ram_sel = access & ~standby & ~reg_hit & to_ram;
    ext_sel = access & ~standby & ~reg_hit & expanded & ~to_ram;
  end

  // R10
  sel_idle_chk: assert final (rd || wr || (!ram_sel && !ext_sel));
endmodule

// File: rtl/ramwin_top.sv
module ramwin_top
  import ramwin_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 8,
  parameter int          WIN_SEL  = 0,
  parameter logic [15:0] REG_ADDR = 16'hFFC4,
  parameter logic [15:0] WIN_END  = 16'hFF7F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              standby_i,
  input  logic [1:0]        mode_i,
  output logic              ram_sel_o,
  output logic              ext_sel_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [15:0] WIN_SIZE = 16'(2048 >> WIN_SEL);
  localparam logic [15:0] WIN_BASE = WIN_END + 16'd1 - WIN_SIZE;

  ctl_t ctl;
  logic reg_hit, expanded;

  assign expanded = (mode_i == 2'd1) || (mode_i == 2'd2);

  ramwin_ctlreg #(.DATA_W(DATA_W)) u_reg (
    .clk(clk), .rst(rst),
    .wr_en(wr_i & reg_hit), .rd_en(rd_i & reg_hit),
    .wdata(wdata_i), .ctl_q(ctl), .rdata_q(rdata_o)
  );

  ramwin_decode #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_END(WIN_END), .REG_ADDR(REG_ADDR)
  ) u_dec (
    .addr(addr_i), .rd(rd_i), .wr(wr_i), .ram_en(ctl.ram_en),
    .expanded(expanded), .standby(standby_i),
    .reg_hit(reg_hit), .ram_sel(ram_sel_o), .ext_sel(ext_sel_o)
  );

  // R10
  sel_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(ram_sel_o && ext_sel_o));
  // R8
  reg_no_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_i == REG_ADDR) |-> (!ram_sel_o && !ext_sel_o));
  // R9
  clear_next_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_i && addr_i == REG_ADDR && !wdata_i[0]) |=> !ram_sel_o);
  // R4
  standby_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (standby_i && !(wr_i && addr_i == REG_ADDR)) |=> $stable(ctl));
  // R12
  standby_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    standby_i |-> (!ram_sel_o && !ext_sel_o));
  // R11
  mode_noext_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'd0 || mode_i == 2'd3) |-> !ext_sel_o);
endmodule

// File: tb/tb_ramwin_top.sv
module tb_ramwin_top;
  logic clk = 0, rst = 1;
  logic [15:0] addr_i = '0;
  logic rd_i = 0, wr_i = 0, standby_i = 0;
  logic [7:0] wdata_i = '0;
  logic [1:0] mode_i = 2'd1;
  logic ram_sel_o, ext_sel_o;
  logic [7:0] rdata_o;
  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  bit done = 0;

  always #4 clk = ~clk;

  ramwin_top dut (.*);

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(logic [15:0] a, bit rd, bit wr, logic [7:0] d,
                     bit e_ram, bit e_ext, string tag);
    @(negedge clk);
    addr_i = a; rd_i = rd; wr_i = wr; wdata_i = d;
    #1;
    chk({tag, " ram_sel"}, 16'(ram_sel_o), 16'(e_ram));
    chk({tag, " ext_sel"}, 16'(ext_sel_o), 16'(e_ext));
  endtask

  task automatic rd_reg(logic [7:0] e, string tag);
    acc(16'hFFC4, 1, 0, 0, 0, 0, tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    rd_i = 0; wr_i = 0;
  endtask

  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk({t, " rdata"}, 16'(rdata_o), 16'(e));
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    rd_reg(8'h0B, "R1 reset value");
    acc(16'hF800, 1, 0, 0, 1, 0, "R1 R5 ram after reset");
    acc(16'hF780, 1, 0, 0, 1, 0, "R5 low edge");
    acc(16'hFF7F, 0, 1, 8'h55, 1, 0, "R5 high edge");
    acc(16'hF77F, 1, 0, 0, 0, 1, "R7 below window");
    acc(16'hFF80, 1, 0, 0, 0, 1, "R7 above window");
    acc(16'h1234, 0, 1, 0, 0, 1, "R7 far outside");
    idle();
    acc(16'hF800, 0, 0, 0, 0, 0, "R10 no strobe");
    acc(16'hFFC4, 0, 1, 8'hFF, 0, 0, "R8 write reg");
    rd_reg(8'hFF, "R3 all ones");
    acc(16'hFFC4, 0, 1, 8'h00, 0, 0, "R8 write zero");
    rd_reg(8'h0A, "R2 reserved stay one");
    acc(16'hF900, 1, 0, 0, 0, 1, "R6 disabled window");
    acc(16'hFFC4, 0, 1, 8'hA4, 0, 0, "R3 write A4");
    rd_reg(8'hAE, "R3 pattern A4");
    acc(16'hFFC4, 0, 1, 8'h01, 0, 0, "R9 set enable");
    acc(16'hF900, 1, 0, 0, 1, 0, "R9 next cycle ram");
    acc(16'hFFC4, 0, 1, 8'h0A, 0, 0, "R9 clear enable");
    acc(16'hF900, 1, 0, 0, 0, 1, "R9 next cycle ext");
    acc(16'hFFC4, 0, 1, 8'hD5, 0, 0, "R4 pattern");
    idle();
    standby_i = 1;
    acc(16'hF900, 1, 0, 0, 0, 0, "R12 standby window");
    acc(16'h2000, 1, 0, 0, 0, 0, "R12 standby outside");
    idle(); idle(); idle();
    standby_i = 0;
    rd_reg(8'hDF, "R4 kept through standby");
    mode_i = 2'd0;
    acc(16'hF900, 1, 0, 0, 1, 0, "R11 mode0 ram");
    acc(16'h2000, 1, 0, 0, 0, 0, "R11 mode0 outside");
    mode_i = 2'd3;
    acc(16'hF77F, 1, 0, 0, 0, 0, "R11 mode3 outside");
    mode_i = 2'd2;
    acc(16'h2000, 1, 0, 0, 0, 1, "R7 mode2 outside");
    acc(16'hFFC4, 0, 1, 8'h00, 0, 0, "R1 clear before reset");
    idle();
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    rd_reg(8'h0B, "R1 reset again");
    acc(16'hFE00, 1, 0, 0, 1, 0, "R1 enabled after reset");
    idle(); idle(); idle();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule